// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Mirroring

This block collects 72 level-sensitive interrupt sources, split into a local group of 8 and two wide groups of 32, and folds them onto one normal interrupt line and one fast interrupt line. Each group has a set-on-one enable port and a clear-on-one disable port at fixed byte offsets on a plain 32-bit read/write bus. Each group also has a read-only pending word that shows which sources are both asserted and enabled.

The local group's pending word is the top-level status word. It holds the local sources, two unmaskable summary flags for the wide groups, and eleven shortcut bits. Each shortcut bit mirrors one wide-group source, so a handler can find that source in one read. A mirrored source never raises its group's summary flag. It can be masked only through its home group's enable and disable ports.

A single control byte routes any one of the 72 raw sources to the fast line. This path ignores the enable masks.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all three enable masks and the fast-route byte are zero, `irq_out` and `fiq_out` are low, and a read of every enable, disable and control offset returns 0.
- R2: A write to enable offset 0x18 (local), 0x10 (wide A) or 0x14 (wide B) sets every mask bit written as 1. A write to disable offset 0x24, 0x1C or 0x20 clears every mask bit written as 1. Bits written as 0 keep their value. A read of either offset of a group returns that group's current mask.
- R3: The pending words of wide A (0x04) and wide B (0x08) equal source AND mask. A pending bit follows its source input one clock later and holds no latched state.
- R4: In the status word at 0x00, bits 7:0 are local source AND local mask. Bit 8 is set when a wide A source that has no shortcut is pending, and bit 9 does the same for wide B. Bits 8 and 9 have no mask of their own.
- R5: Status bits 10 to 14 mirror pending wide A sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 mirror pending wide B sources 21, 22, 23, 24, 25 and 30, in that order. A mirrored source still shows in its own group's pending word.
- R6: A shortcut bit is gated only by its home group's mask. Writes to the local enable and disable offsets do not change it.
- R7: `irq_out` is high exactly when some bit 0 to 20 of the status word is set.
- R8: The control byte at 0x0C holds a source index in bits 6:0 and a fast-line enable in bit 7. Indexes 0-31 select wide A, 32-63 select wide B and 64-71 select the local group. Any other index selects nothing. Bits 31:8 are not stored and read as 0.
- R9: `fiq_out` is the selected raw source, one clock after the input, whatever the enable masks hold. A source that is both enabled and selected drives both outputs at once.
- R10: Status bits 31:21, local mask bits 31:8 and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_local | input | 8 | Local group source levels |
| src_wide_a | input | 32 | Wide group A source levels |
| src_wide_b | input | 32 | Wide group B source levels |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench drives a mirrored source alone, next to an unmirrored neighbour, and with every source high. A design that leaked a mirrored source into its summary flag, or placed a shortcut at the wrong bit, shows a different status word in these cases. It then masks a mirrored source in its home group while the local mask is fully open, and clears the local mask while the home group enables it. Gating the shortcut with the wrong mask makes the shortcut bit and `irq_out` disagree with the expected values. For the fast line it checks that each index range lands in the right group, including the first local index and an index past the end. It also checks that a masked source still reaches `fiq_out`, and that a write to the control byte keeps only its low byte.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_local,
  input  logic [31:0]       src_wide_a,
  input  logic [31:0]       src_wide_b,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int LOC_N = 8;
  localparam int WIDE_N = 32;
  localparam int SCA_N = 5;
  localparam int SCB_N = 6;
  localparam int TOTAL_N = 2 * WIDE_N + LOC_N;
  localparam int SEL_W = 7;
  localparam int STAT_USED = LOC_N + 2 + SCA_N + SCB_N;
  localparam int SCA_IDX [SCA_N] = '{7, 9, 10, 18, 19};
  localparam int SCB_IDX [SCB_N] = '{21, 22, 23, 24, 25, 30};

  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_PEND_A = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_PEND_B = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_FIQ    = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_EN_A   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_EN_B   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_EN_L   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_DIS_A  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_DIS_B  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_DIS_L  = ADDR_W'('h24);

  logic [LOC_N-1:0]  loc_q, mask_l;
  logic [WIDE_N-1:0] wa_q, wb_q, mask_a, mask_b;
  logic [7:0]        fiq_ctl;

  logic [LOC_N-1:0]  pend_l;
  logic [WIDE_N-1:0] pend_a, pend_b, sc_mask_a, sc_mask_b;
  logic [SCA_N-1:0]  sc_a;
  logic [SCB_N-1:0]  sc_b;
  logic              sum_a, sum_b;
  logic [31:0]       stat;
  logic [127:0]      fiq_pool;

  wire wr_en_l  = bus_we && bus_addr == A_EN_L;
  wire wr_en_a  = bus_we && bus_addr == A_EN_A;
  wire wr_en_b  = bus_we && bus_addr == A_EN_B;
  wire wr_dis_l = bus_we && bus_addr == A_DIS_L;
  wire wr_dis_a = bus_we && bus_addr == A_DIS_A;
  wire wr_dis_b = bus_we && bus_addr == A_DIS_B;
  wire wr_fiq   = bus_we && bus_addr == A_FIQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= '0;
      wa_q  <= '0;
      wb_q  <= '0;
    end else begin
      loc_q <= src_local;
      wa_q  <= src_wide_a;
      wb_q  <= src_wide_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_l  <= '0;
      mask_a  <= '0;
      mask_b  <= '0;
      fiq_ctl <= '0;
    end else begin
      if (wr_en_l)  mask_l <= mask_l | bus_wdata[LOC_N-1:0];
      if (wr_dis_l) mask_l <= mask_l & ~bus_wdata[LOC_N-1:0];
      if (wr_en_a)  mask_a <= mask_a | bus_wdata;
      if (wr_dis_a) mask_a <= mask_a & ~bus_wdata;
      if (wr_en_b)  mask_b <= mask_b | bus_wdata;
      if (wr_dis_b) mask_b <= mask_b & ~bus_wdata;
      if (wr_fiq)   fiq_ctl <= bus_wdata[7:0];
    end
  end

  assign pend_l = loc_q & mask_l;
  assign pend_a = wa_q & mask_a;
  assign pend_b = wb_q & mask_b;

  always_comb begin
    sc_mask_a = '0;
    sc_mask_b = '0;
    for (int i = 0; i < SCA_N; i++) begin
      sc_a[i] = pend_a[SCA_IDX[i]];
      sc_mask_a[SCA_IDX[i]] = 1'b1;
    end
    for (int j = 0; j < SCB_N; j++) begin
      sc_b[j] = pend_b[SCB_IDX[j]];
      sc_mask_b[SCB_IDX[j]] = 1'b1;
    end
  end

  assign sum_a = |(pend_a & ~sc_mask_a);
  assign sum_b = |(pend_b & ~sc_mask_b);
  assign stat  = {{(32-STAT_USED){1'b0}}, sc_b, sc_a, sum_b, sum_a, pend_l};
  assign irq_out = |stat[STAT_USED-1:0];

  assign fiq_pool = {{(128-TOTAL_N){1'b0}}, loc_q, wb_q, wa_q};
  assign fiq_out  = fiq_ctl[7] && fiq_pool[fiq_ctl[SEL_W-1:0]];

  always_comb begin
    case (bus_addr)
      A_STAT:           bus_rdata = stat;
      A_PEND_A:         bus_rdata = pend_a;
      A_PEND_B:         bus_rdata = pend_b;
      A_FIQ:            bus_rdata = {24'b0, fiq_ctl};
      A_EN_A, A_DIS_A:  bus_rdata = mask_a;
      A_EN_B, A_DIS_B:  bus_rdata = mask_b;
      A_EN_L, A_DIS_L:  bus_rdata = {{(32-LOC_N){1'b0}}, mask_l};
      default:          bus_rdata = '0;
    endcase
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_a |=> ((mask_a & $past(bus_wdata)) == $past(bus_wdata)));
  assert_dis_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_a |=> ((mask_a & $past(bus_wdata)) == '0));
  assert_summary_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_a & ~sc_mask_a) == '0) |-> !stat[LOC_N]);
  assert_sc_home_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_a[7] |-> !stat[LOC_N+2]);
  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_local == '0 && src_wide_a == '0 && src_wide_b == '0) |=> !irq_out);
  assert_fiq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_ctl[7] |-> !fiq_out);
  assert_fiq_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_ctl == 8'h80 && !wr_fiq && src_wide_a[0]) |=> fiq_out);
endmodule

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src_local;
  logic [31:0] src_wide_a, src_wide_b;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_irq_ctrl #(.ADDR_W(6)) dut (
    .clk(clk), .rst_n(rst_n), .src_local(src_local), .src_wide_a(src_wide_a),
    .src_wide_b(src_wide_b), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // {local, wide A, wide B, expected status word}
  localparam logic [103:0] VEC [12] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {8'h01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
    {8'h00, 32'h0000_0200, 32'h0000_0000, 32'h0000_0800},
    {8'h00, 32'h0008_0000, 32'h0000_0000, 32'h0000_4000},
    {8'h00, 32'h0000_0000, 32'h0020_0000, 32'h0000_8000},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
    {8'h00, 32'h0000_0000, 32'h0000_0001, 32'h0000_0200},
    {8'h00, 32'h0000_0082, 32'h0000_0000, 32'h0000_0500},
    {8'h80, 32'h0004_0400, 32'h03C0_0000, 32'h000F_3080},
    {8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h001F_FFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drive(input logic [7:0] l, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    src_local = l; src_wide_a = a; src_wide_b = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_local = '0; src_wide_a = '0; src_wide_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h18, r); chk("R1 local mask", r, 0);
    rd(6'h10, r); chk("R1 wide A mask", r, 0);
    rd(6'h14, r); chk("R1 wide B mask", r, 0);
    rd(6'h0C, r); chk("R1 fiq ctl", r, 0);
    chk("R1 outputs", {30'b0, irq_out, fiq_out}, 0);

    // R2 set/clear semantics
    wr(6'h10, 32'h0000_00F0);
    wr(6'h10, 32'h0000_000F);
    rd(6'h10, r); chk("R2 enable set", r, 32'h0000_00FF);
    wr(6'h1C, 32'h0000_0003);
    rd(6'h10, r); chk("R2 disable clear", r, 32'h0000_00FC);
    rd(6'h1C, r); chk("R2 disable offset reads mask", r, 32'h0000_00FC);

    // R3 pending follows input one clock later
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h10, 32'h0000_0100);
    @(negedge clk);
    src_wide_a = 32'h0000_0101;
    rd(6'h04, r); chk("R3 before edge", r, 0);
    @(negedge clk);
    rd(6'h04, r); chk("R3 after edge", r, 32'h0000_0100);
    drive(8'h00, 32'h0, 32'h0);
    rd(6'h04, r); chk("R3 no latch", r, 0);

    // R4 R5 R7 vector table with all masks open
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h18, r); chk("R10 local mask upper zero", r, 32'h0000_00FF);
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][103:96], VEC[i][95:64], VEC[i][63:32]);
      rd(6'h00, r); chk("R4 R5 status word", r, VEC[i][31:0]);
      rd(6'h04, r); chk("R5 wide A pending", r, VEC[i][95:64]);
      chk("R7 irq", {31'b0, irq_out}, {31'b0, VEC[i][31:0] != 0});
    end

    // R6 shortcut masked only in its home group
    drive(8'h00, 32'h0, 32'h0);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    drive(8'h00, 32'h0000_0080, 32'h0);
    rd(6'h00, r); chk("R6 home-masked shortcut", r, 0);
    chk("R6 irq low", {31'b0, irq_out}, 0);
    wr(6'h10, 32'h0000_0080);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h18, r); chk("R6 local mask cleared", r, 0);
    rd(6'h00, r); chk("R6 local disable no effect", r, 32'h0000_0400);
    chk("R6 irq high", {31'b0, irq_out}, 1);

    // R4 summary unmaskable by local group
    wr(6'h10, 32'h0000_0002);
    drive(8'h00, 32'h0000_0002, 32'h0);
    rd(6'h00, r); chk("R4 summary with local mask clear", r, 32'h0000_0100);

    // R8 R9 fast line
    wr(6'h1C, 32'hFFFF_FFFF);
    drive(8'h00, 32'h0000_0020, 32'h0);
    wr(6'h0C, 32'h0000_0085);
    chk("R9 fiq ignores mask", {30'b0, irq_out, fiq_out}, 32'h1);
    wr(6'h0C, 32'h0000_00A5);
    chk("R8 wide A not picked by 37", {31'b0, fiq_out}, 0);
    drive(8'h00, 32'h0, 32'h0000_0020);
    chk("R8 index 37 wide B", {31'b0, fiq_out}, 1);
    wr(6'h0C, 32'h0000_00C0);
    drive(8'h01, 32'h0, 32'h0);
    chk("R8 index 64 local", {31'b0, fiq_out}, 1);
    wr(6'h0C, 32'h0000_00C8);
    drive(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R8 index 72 selects none", {31'b0, fiq_out}, 0);
    drive(8'h00, 32'h0000_0020, 32'h0);
    wr(6'h0C, 32'hFFFF_FF05);
    rd(6'h0C, r); chk("R8 low byte only", r, 32'h0000_0005);
    chk("R8 enable bit off", {31'b0, fiq_out}, 0);
    wr(6'h10, 32'h0000_0020);
    wr(6'h0C, 32'h0000_0085);
    chk("R9 both outputs", {30'b0, irq_out, fiq_out}, 32'h3);

    // R10 unmapped
    rd(6'h28, r); chk("R10 unmapped", r, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule